// File: doc/BRIEF.md
# Swept-Sensor Frame Readout Sequencer

This block produces the digital output stream of a swept linear image sensor. The array has 8 rows and 280 columns of 4-bit pixels. On every pixel clock the block emits one byte made of two nibbles: the pixel from an odd-numbered row and the pixel from the even-numbered row just below it. Each column therefore takes four clocks. After the last real column the block appends one extra synchronisation column of four bytes. The first two bytes carry a fixed marker. The last two carry a temperature code and three auxiliary fields. The scan then returns straight to the first column, without any reset between frames.

The pixel values themselves come from a stimulus port that stands in for the converters. The block publishes the column index and row-pair index of the byte it is forming, and the stimulus source answers on the pixel inputs. The scan position advances on the falling edge of the pixel clock. The output byte is registered on the rising edge. After reset is released the block waits a fixed number of clocks before the first pixel byte appears. An active-low output enable releases the two nibble buses to high impedance while it is high.

Top module: `sweep_readout_seq`

## Requirements
- R1: While `rst` is high, `col_idx` and `pair_idx` are 0, the registered byte is 0 (seen on the pads when they drive), and no scanning takes place.
- R2: After `rst` falls, the bytes stay 0 until 4 falling edges of `pclk` have passed. The byte for column 0, row pair 0 appears at the rising edge that follows the 4th falling edge.
- R3: For a real column c and row pair p, the odd nibble carries row 2p+1 (`pix_odd`) and the even nibble carries row 2p+2 (`pix_even`), both as presented for (c, p). Bit 3 of each nibble is the most significant bit.
- R4: Each falling edge after the warm-up advances `pair_idx` by one. After pair 3, `pair_idx` returns to 0 and `col_idx` advances. One frame is 281 columns x 4 pairs = 1124 clocks, and `col_idx` never exceeds 280.
- R5: After column 280, pair 3, the scan returns to column 0, pair 0 on the next falling edge without any reset, and the frames repeat back to back.
- R6: In column 280, pairs 0 and 1 output odd = {1,1,1,`sync_flag`} (flag in bit 0) and even = 0000.
- R7: In column 280, pair 2 outputs odd = `aux_a` and even = `temp_code`. Pair 3 outputs odd = `aux_b` and even = `aux_c`.
- R8: The output byte changes only on the rising edge of `pclk`. It is unchanged across the falling edge.
- R9: `bus_drive` equals the inverse of `oe_n`. While `oe_n` is high, both pads are released to high impedance. While `oe_n` is low, the pads carry the registered byte. `oe_n` has no effect on the scan sequence.
- R10: A reset raised in the middle of a frame restarts the scan at column 0, pair 0, with a fresh warm-up of 4 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Pixel clock; scan advances on the falling edge, data on the rising edge |
| rst | input | 1 | Active-high asynchronous reset; holds the sequencer |
| oe_n | input | 1 | Active-low output enable for the nibble pads |
| pix_odd | input | 4 | Stimulus pixel for odd row 2p+1 of the addressed column |
| pix_even | input | 4 | Stimulus pixel for even row 2p+2 of the addressed column |
| temp_code | input | 4 | Temperature code placed in the third sync-column byte |
| sync_flag | input | 1 | Low bit of the marker nibble in the first two sync bytes |
| aux_a | input | 4 | Odd nibble of the third sync-column byte |
| aux_b | input | 4 | Odd nibble of the fourth sync-column byte |
| aux_c | input | 4 | Even nibble of the fourth sync-column byte |
| odd_pad | output | 4 | Odd-row nibble, high impedance when disabled |
| even_pad | output | 4 | Even-row nibble, high impedance when disabled |
| bus_drive | output | 1 | High while the pads are driven |
| col_idx | output | 9 | Column index of the byte being formed (280 = sync column) |
| pair_idx | output | 2 | Row-pair index of the byte being formed |

## Verification
The pixel stimulus cycles through four patterns, one per frame: an arithmetic function of column and row, all ones, a checkerboard, and an XOR mix. The all-ones and checkerboard patterns expose stuck or swapped nibble bits. The arithmetic and XOR patterns tell the odd row apart from the even row and reveal off-by-one errors in the column or pair position. The sync-column inputs change value every frame, and the marker flag toggles, so a byte taken from the wrong slot or from a stale value does not match. Output enable is pulsed on an irregular rhythm across whole frames, and a reset is raised in the middle of a frame, to show that neither disturbs the scan position or the warm-up count.

// File: rtl/sweep_readout_pkg.sv
package sweep_readout_pkg;

   // Slots of the trailing synchronisation column, indexed by row pair.
   typedef enum int unsigned {
      SLOT_MARK_A = 0,
      SLOT_MARK_B = 1,
      SLOT_THERMO = 2,
      SLOT_TAIL   = 3
   } sync_slot_e;

   localparam int unsigned SYNC_SLOTS = 4;

   // Smallest legal geometry: four row pairs are needed to hold every slot.
   localparam int unsigned MIN_ROWS = 2 * SYNC_SLOTS;

endpackage

// File: rtl/sweep_warmup.sv
// Holds the scan until a fixed number of falling edges have passed after reset.
module sweep_warmup #(
   parameter int unsigned PIPE = 4,
   localparam int unsigned CW = (PIPE > 1) ? $clog2(PIPE) : 1
)(
   input  logic pclk,
   input  logic rst,
   output logic run
);

   generate
      if (PIPE == 1) begin : g_single
         always_ff @(negedge pclk or posedge rst) begin
            if (rst) run <= 1'b0;
            else     run <= 1'b1;
         end
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(negedge pclk or posedge rst) begin
            if (rst) begin
               cnt <= '0;
               run <= 1'b0;
            end else if (!run) begin
               if (cnt == CW'(PIPE - 1)) run <= 1'b1;
               else                      cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sweep_scan_ctr.sv
// Column / row-pair position, advanced on the falling clock edge.
module sweep_scan_ctr #(
   parameter int unsigned COLS   = 280,
   parameter int unsigned PAIRS  = 4,
   parameter int unsigned COL_W  = 9,
   parameter int unsigned PAIR_W = 2
)(
   input  logic              pclk,
   input  logic              rst,
   input  logic              adv,
   output logic [COL_W-1:0]  col,
   output logic [PAIR_W-1:0] pair
);

   localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(COLS);
   localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(PAIRS - 1);

   logic pair_end;
   assign pair_end = (pair == LAST_PAIR);

   always_ff @(negedge pclk or posedge rst) begin
      if (rst) begin
         col  <= '0;
         pair <= '0;
      end else if (adv) begin
         if (pair_end) begin
            pair <= '0;
            col  <= (col == LAST_COL) ? '0 : col + 1'b1;
         end else begin
            pair <= pair + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sweep_byte_mux.sv
// Chooses the byte for the current position: stimulus pixels or a sync slot.
module sweep_byte_mux
   import sweep_readout_pkg::*;
#(
   parameter int unsigned COLS   = 280,
   parameter int unsigned NIB    = 4,
   parameter int unsigned COL_W  = 9,
   parameter int unsigned PAIR_W = 2
)(
   input  logic [COL_W-1:0]  col,
   input  logic [PAIR_W-1:0] pair,
   input  logic [NIB-1:0]    pix_odd,
   input  logic [NIB-1:0]    pix_even,
   input  logic [NIB-1:0]    temp_code,
   input  logic              sync_flag,
   input  logic [NIB-1:0]    aux_a,
   input  logic [NIB-1:0]    aux_b,
   input  logic [NIB-1:0]    aux_c,
   output logic [NIB-1:0]    nx_odd,
   output logic [NIB-1:0]    nx_even
);

   logic           in_sync;
   logic [NIB-1:0] mark_nib;

   assign in_sync  = (col == COL_W'(COLS));
   assign mark_nib = {{(NIB-1){1'b1}}, sync_flag};

   always_comb begin
      nx_odd  = pix_odd;
      nx_even = pix_even;
      if (in_sync) begin
         case (int'(pair))
            SLOT_MARK_A, SLOT_MARK_B: begin
               nx_odd  = mark_nib;
               nx_even = '0;
            end
            SLOT_THERMO: begin
               nx_odd  = aux_a;
               nx_even = temp_code;
            end
            SLOT_TAIL: begin
               nx_odd  = aux_b;
               nx_even = aux_c;
            end
            default: begin
               nx_odd  = '0;
               nx_even = '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/sweep_pad_drv.sv
// Rising-edge output register and per-bit tristate pads.
module sweep_pad_drv #(
   parameter int unsigned NIB = 4
)(
   input  logic           pclk,
   input  logic           rst,
   input  logic           run,
   input  logic           oe_n,
   input  logic [NIB-1:0] nx_odd,
   input  logic [NIB-1:0] nx_even,
   output logic [NIB-1:0] q_odd,
   output logic [NIB-1:0] q_even,
   output logic [NIB-1:0] odd_pad,
   output logic [NIB-1:0] even_pad,
   output logic           drive
);

   always_ff @(posedge pclk or posedge rst) begin
      if (rst) begin
         q_odd  <= '0;
         q_even <= '0;
      end else if (!run) begin
         q_odd  <= '0;
         q_even <= '0;
      end else begin
         q_odd  <= nx_odd;
         q_even <= nx_even;
      end
   end

   assign drive = ~oe_n;

   generate
      for (genvar b = 0; b < NIB; b++) begin : g_pad
         assign odd_pad[b]  = drive ? q_odd[b]  : 1'bz;
         assign even_pad[b] = drive ? q_even[b] : 1'bz;
      end
   endgenerate

endmodule

// File: rtl/sweep_readout_seq.sv
module sweep_readout_seq
   import sweep_readout_pkg::*;
#(
   parameter int unsigned ROWS = 8,
   parameter int unsigned COLS = 280,
   parameter int unsigned NIB  = 4,
   parameter int unsigned PIPE = 4,
   localparam int unsigned PAIRS  = ROWS / 2,
   localparam int unsigned COL_W  = $clog2(COLS + 1),
   localparam int unsigned PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1
)(
   input  logic              pclk,
   input  logic              rst,
   input  logic              oe_n,
   input  logic [NIB-1:0]    pix_odd,
   input  logic [NIB-1:0]    pix_even,
   input  logic [NIB-1:0]    temp_code,
   input  logic              sync_flag,
   input  logic [NIB-1:0]    aux_a,
   input  logic [NIB-1:0]    aux_b,
   input  logic [NIB-1:0]    aux_c,
   output logic [NIB-1:0]    odd_pad,
   output logic [NIB-1:0]    even_pad,
   output logic              bus_drive,
   output logic [COL_W-1:0]  col_idx,
   output logic [PAIR_W-1:0] pair_idx
);

   generate
      if (ROWS < MIN_ROWS || (ROWS % 2) != 0) begin : g_bad_rows
         $error("ROWS must be even and at least %0d", MIN_ROWS);
      end
      if (NIB < 2) begin : g_bad_nib
         $error("NIB must be at least 2");
      end
      if (PIPE < 1) begin : g_bad_pipe
         $error("PIPE must be at least 1");
      end
      if (COLS < 1) begin : g_bad_cols
         $error("COLS must be at least 1");
      end
   endgenerate

   logic           seq_run;
   logic [NIB-1:0] nx_odd, nx_even;
   logic [NIB-1:0] q_odd, q_even;

   sweep_warmup #(.PIPE(PIPE)) u_warm (
      .pclk (pclk),
      .rst  (rst),
      .run  (seq_run)
   );

   sweep_scan_ctr #(
      .COLS(COLS), .PAIRS(PAIRS), .COL_W(COL_W), .PAIR_W(PAIR_W)
   ) u_scan (
      .pclk (pclk),
      .rst  (rst),
      .adv  (seq_run),
      .col  (col_idx),
      .pair (pair_idx)
   );

   sweep_byte_mux #(
      .COLS(COLS), .NIB(NIB), .COL_W(COL_W), .PAIR_W(PAIR_W)
   ) u_mux (
      .col       (col_idx),
      .pair      (pair_idx),
      .pix_odd   (pix_odd),
      .pix_even  (pix_even),
      .temp_code (temp_code),
      .sync_flag (sync_flag),
      .aux_a     (aux_a),
      .aux_b     (aux_b),
      .aux_c     (aux_c),
      .nx_odd    (nx_odd),
      .nx_even   (nx_even)
   );

   sweep_pad_drv #(.NIB(NIB)) u_pads (
      .pclk     (pclk),
      .rst      (rst),
      .run      (seq_run),
      .oe_n     (oe_n),
      .nx_odd   (nx_odd),
      .nx_even  (nx_even),
      .q_odd    (q_odd),
      .q_even   (q_even),
      .odd_pad  (odd_pad),
      .even_pad (even_pad),
      .drive    (bus_drive)
   );

endmodule

// File: rtl/sweep_readout_chk.sv
module sweep_readout_chk #(
   parameter int unsigned COLS   = 280,
   parameter int unsigned PAIRS  = 4,
   parameter int unsigned NIB    = 4,
   parameter int unsigned COL_W  = 9,
   parameter int unsigned PAIR_W = 2
)(
   input logic              pclk,
   input logic              rst,
   input logic              oe_n,
   input logic              bus_drive,
   input logic              run,
   input logic [COL_W-1:0]  col,
   input logic [PAIR_W-1:0] pair,
   input logic [NIB-1:0]    byte_odd,
   input logic [NIB-1:0]    byte_even
);

   localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(COLS);
   localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(PAIRS - 1);

   p_hiz_r9: assert property (@(posedge pclk) disable iff (rst)
      oe_n |-> !bus_drive);

   p_idle_zero_r2: assert property (@(posedge pclk) disable iff (rst)
      !$past(run) |-> (byte_odd == '0 && byte_even == '0));

   p_pair_step_r4: assert property (@(posedge pclk) disable iff (rst)
      ($past(run) && run && $past(pair) != LAST_PAIR)
      |-> (pair == PAIR_W'($past(pair) + 1'b1) && col == $past(col)));

   p_col_range_r4: assert property (@(posedge pclk) disable iff (rst)
      col <= LAST_COL);

   p_col_wrap_r5: assert property (@(posedge pclk) disable iff (rst)
      ($past(run) && run && $past(pair) == LAST_PAIR && $past(col) == LAST_COL)
      |-> (col == '0 && pair == '0));

   p_mark_r6: assert property (@(posedge pclk) disable iff (rst)
      ($past(run) && $past(col) == LAST_COL && int'($past(pair)) < 2)
      |-> (byte_odd[NIB-1:1] == '1 && byte_even == '0));

endmodule

bind sweep_readout_seq sweep_readout_chk #(
   .COLS(COLS), .PAIRS(PAIRS), .NIB(NIB), .COL_W(COL_W), .PAIR_W(PAIR_W)
) u_chk (
   .pclk      (pclk),
   .rst       (rst),
   .oe_n      (oe_n),
   .bus_drive (bus_drive),
   .run       (seq_run),
   .col       (col_idx),
   .pair      (pair_idx),
   .byte_odd  (q_odd),
   .byte_even (q_even)
);

// File: tb/sweep_readout_seq_tb_top.sv
`timescale 1ns/1ps
module sweep_readout_seq_tb_top;

   localparam int COLS  = 280;
   localparam int PAIRS = 4;
   localparam int FRAME = (COLS + 1) * PAIRS;
   localparam int PIPE  = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       oe_n = 1'b0;
   logic [3:0] pix_odd, pix_even;
   logic [3:0] temp_code = 4'd0;
   logic       sync_flag = 1'b0;
   logic [3:0] aux_a = 4'd0, aux_b = 4'd0, aux_c = 4'd0;
   wire  [3:0] odd_pad, even_pad;
   wire        bus_drive;
   wire  [8:0] col_idx;
   wire  [1:0] pair_idx;

   int n_chk = 0;
   int n_bad = 0;
   int nfe = 0;
   int cyc = 0;
   int pat_mode = 0;
   bit second_run = 0;
   bit have_last = 0;
   bit done = 0;
   logic [3:0] last_o, last_e;

   always #5 clk = ~clk;

   function automatic logic [3:0] px(int c, int r, int m);
      case (m)
         0:       return 4'((c * 3 + r * 5 + 1) & 15);
         1:       return 4'hF;
         2:       return (((c + r) & 1) != 0) ? 4'hF : 4'h0;
         default: return 4'((c ^ (r << 2)) & 15);
      endcase
   endfunction

   always_comb begin
      pix_odd  = px(int'(col_idx), 2 * int'(pair_idx) + 1, pat_mode);
      pix_even = px(int'(col_idx), 2 * int'(pair_idx) + 2, pat_mode);
   end

   sweep_readout_seq dut_i (
      .pclk(clk), .rst(rst), .oe_n(oe_n),
      .pix_odd(pix_odd), .pix_even(pix_even),
      .temp_code(temp_code), .sync_flag(sync_flag),
      .aux_a(aux_a), .aux_b(aux_b), .aux_c(aux_c),
      .odd_pad(odd_pad), .even_pad(even_pad), .bus_drive(bus_drive),
      .col_idx(col_idx), .pair_idx(pair_idx)
   );

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   task automatic one_cycle(bit pulse_oe);
      int idx, c, p, eo, ee;
      string tag;
      @(negedge clk);
      if (!rst) nfe++;
      #2;
      // R8: byte must hold across the falling edge
      if (have_last && bus_drive) begin
         chk(odd_pad == last_o, "R8 odd hold", int'(odd_pad), int'(last_o));
         chk(even_pad == last_e, "R8 even hold", int'(even_pad), int'(last_e));
      end
      oe_n = pulse_oe ? ((cyc % 7) == 3 || (cyc % 11) == 5) : 1'b0;
      cyc++;
      @(posedge clk);
      #2;
      // R9: enable follows oe_n
      chk(bus_drive == !oe_n, "R9 drive", int'(bus_drive), int'(!oe_n));
      if (rst || nfe < PIPE) begin
         tag = rst ? (second_run ? "R10 reset" : "R1 reset") : "R2 warmup";
         chk(col_idx == 9'd0, tag, int'(col_idx), 0);
         chk(pair_idx == 2'd0, tag, int'(pair_idx), 0);
         if (!oe_n) begin
            chk(odd_pad == 4'd0, tag, int'(odd_pad), 0);
            chk(even_pad == 4'd0, tag, int'(even_pad), 0);
         end
      end else begin
         idx = (nfe - PIPE) % FRAME;
         c = idx / PAIRS;
         p = idx % PAIRS;
         tag = (nfe > PIPE && idx == 0) ? "R5 wrap" :
               ((nfe == PIPE) ? (second_run ? "R10 restart" : "R2 first") : "R4 position");
         chk(int'(col_idx) == c, tag, int'(col_idx), c);
         chk(int'(pair_idx) == p, tag, int'(pair_idx), p);
         if (c == COLS) begin
            case (p)
               0, 1: begin eo = 14 + int'(sync_flag); ee = 0; tag = "R6 marker"; end
               2:    begin eo = int'(aux_a); ee = int'(temp_code); tag = "R7 thermo"; end
               default: begin eo = int'(aux_b); ee = int'(aux_c); tag = "R7 tail"; end
            endcase
         end else begin
            eo = int'(px(c, 2 * p + 1, pat_mode));
            ee = int'(px(c, 2 * p + 2, pat_mode));
            tag = "R3 pixel";
         end
         if (!oe_n) begin
            chk(int'(odd_pad) == eo, tag, int'(odd_pad), eo);
            chk(int'(even_pad) == ee, tag, int'(even_pad), ee);
         end
      end
      if (bus_drive) begin
         last_o = odd_pad;
         last_e = even_pad;
         have_last = 1;
      end else begin
         have_last = 0;
      end
   endtask

   task automatic update_inputs();
      int f;
      if (nfe >= PIPE) begin
         f = (nfe - PIPE) / FRAME;
         pat_mode  = (f + (second_run ? 2 : 0)) % 4;
         temp_code = 4'((f * 5 + 3) & 15);
         sync_flag = f[0];
         aux_a     = 4'((f * 3 + 9) & 15);
         aux_b     = 4'((f * 7 + 2) & 15);
         aux_c     = 4'((f * 11 + 6) & 15);
      end
   endtask

   initial begin
      repeat (3) one_cycle(0);
      rst = 1'b0;
      nfe = 0;
      for (int i = 0; i < 3 * FRAME + 40; i++) begin
         one_cycle(1);
         update_inputs();
      end
      // R10: reset in the middle of a frame
      have_last = 0;
      rst = 1'b1;
      nfe = 0;
      second_run = 1;
      repeat (3) one_cycle(1);
      rst = 1'b0;
      for (int i = 0; i < FRAME + 60; i++) begin
         one_cycle(1);
         update_inputs();
      end
      done = 1;
      summary();
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         summary();
         $finish;
      end
   end

endmodule